// File: doc/BRIEF.md
# USB Host Transaction Error Tracker

This block closes each transaction phase on the host side of a USB link. When a data packet from a device finishes arriving, the block decides between two outcomes. If the packet is intact and could be stored, the host acknowledges it. Otherwise the data is thrown away and the host stays silent. A host never returns NAK or STALL, so ACK is the only handshake this block can issue.

The block also watches the bus after every end-of-packet. If no device response begins within 19 bit times, it flags a turnaround timeout. Both a CRC failure on received data and a turnaround timeout count against the same per-descriptor error budget. That budget is a small down-counter loaded from the transfer descriptor. When a decrement takes it to zero, an exhausted flag rises so the scheduler can retire the descriptor as stalled.

Packet framing, descriptor memory access and scheduling sit outside this block. It sees only strobes and flags from the receive path and a load strobe from the descriptor fetch logic.

Top module: `usb_txn_err_tracker`

## Requirements
- R1: After a synchronous active-low reset, send_ack, discard_data, turnaround_timeout and err_exhausted are 0 and err_count is 0.
- R2: When rx_end is high with rx_crc_ok high and rx_overrun low, send_ack is high for exactly the next cycle and discard_data stays low.
- R3: When rx_end is high with rx_crc_ok low, discard_data is high for exactly the next cycle and send_ack stays low.
- R4: When rx_end is high with rx_overrun high and rx_crc_ok high, discard_data is high for the next cycle, send_ack stays low, and err_count does not change.
- R5: When 19 bit_tick cycles follow an eop_pulse with no rx_start, turnaround_timeout is high for exactly one cycle, the cycle after the 19th tick. No further pulse follows until the next eop_pulse.
- R6: An rx_start after an eop_pulse stops the timer, and no timeout follows. This includes an rx_start in the same cycle as the 19th tick.
- R7: An eop_pulse while the timer is running restarts the 19-tick window from zero.
- R8: A CRC failure on rx_end, or a turnaround timeout, lowers err_count by one in the cycle the discard or timeout pulse appears. When both happen in the same cycle, err_count drops by one only.
- R9: An error while err_count is 0 leaves err_count at 0 (no wrap).
- R10: err_exhausted goes high when a decrement takes err_count from 1 to 0. It stays high until the next load.
- R11: cnt_load high sets err_count to cnt_load_val and clears err_exhausted on the next cycle. A load takes priority over an error in the same cycle.
- R12: A successful reception (R2) leaves err_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eop_pulse | input | 1 | End of packet detected on the bus; starts or restarts the turnaround timer |
| bit_tick | input | 1 | One pulse per USB bit time |
| rx_start | input | 1 | A device response has started arriving |
| rx_end | input | 1 | A received data packet has completed |
| rx_crc_ok | input | 1 | CRC of the completed packet is good (valid with rx_end) |
| rx_overrun | input | 1 | Receive buffer could not take the data (valid with rx_end) |
| cnt_load | input | 1 | Load the error count from the descriptor |
| cnt_load_val | input | 2 | Error count value to load |
| send_ack | output | 1 | One-cycle request to transmit an ACK handshake |
| discard_data | output | 1 | One-cycle strobe to drop the received data |
| turnaround_timeout | output | 1 | One-cycle turnaround timeout pulse |
| err_count | output | 2 | Current error count |
| err_exhausted | output | 1 | Error count reached zero through a decrement |

## Verification
Two pairs of events can land in the same cycle. The first pair is the 19th bit tick and a response start. The bench drives rx_start together with that tick and expects no timeout and an unchanged count. The second pair is a timeout expiry and a CRC-failed rx_end, driven together in one cycle. There the bench expects discard_data and turnaround_timeout to rise together and err_count to drop by exactly one. A further collision, a load against a CRC failure, is judged by the count showing the loaded value.

// File: rtl/usb_err_pkg.sv
// Shared types for the host transaction error tracker.
package usb_err_pkg;
    // Outcome of a completed IN data reception.
    typedef enum logic [1:0] {
        VERDICT_NONE = 2'd0,
        VERDICT_ACK  = 2'd1,
        VERDICT_DROP = 2'd2
    } rx_verdict_e;
endpackage

// File: rtl/usb_turnaround_timer.sv
// Turnaround timer: counts bit ticks after an end of packet and flags a
// timeout when LIMIT ticks pass with no response start.
// Assumes eop_pulse and rx_start are single-cycle strobes; eop wins a tie.
module usb_turnaround_timer #(
    parameter int LIMIT = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eop_pulse,
    input  logic bit_tick,
    input  logic rx_start,
    output logic expire_now,
    output logic timeout_q
);
    localparam int TMR_W = $clog2(LIMIT + 1);

    logic             armed_q;
    logic [TMR_W-1:0] bits_q;

    // Expiry: the last tick of the window arrives with no response and no restart.
    assign expire_now = armed_q && bit_tick && !rx_start && !eop_pulse &&
                        (bits_q == TMR_W'(LIMIT - 1));

    // Window state: restart on eop, stop on response start, advance on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            bits_q    <= '0;
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= expire_now;
            if (eop_pulse) begin
                armed_q <= 1'b1;
                bits_q  <= '0;
            end else if (rx_start) begin
                armed_q <= 1'b0;
                bits_q  <= '0;
            end else if (armed_q && bit_tick) begin
                if (bits_q == TMR_W'(LIMIT - 1)) begin
                    armed_q <= 1'b0;
                    bits_q  <= '0;
                end else begin
                    bits_q <= bits_q + TMR_W'(1);
                end
            end
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_q |=> !timeout_q);
    a_r6_start_blocks_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !timeout_q);
    a_r7_eop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |=> (!timeout_q && armed_q && bits_q == '0));
    a_r5_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q < TMR_W'(LIMIT));
endmodule

// File: rtl/usb_in_handshake.sv
// IN handshake decision: a completed packet is acknowledged when intact
// and storable, otherwise dropped with no handshake. The host never NAKs
// or STALLs. rx_crc_ok and rx_overrun are only meaningful with rx_end.
module usb_in_handshake
    import usb_err_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_end,
    input  logic        rx_crc_ok,
    input  logic        rx_overrun,
    output rx_verdict_e verdict_q
);
    rx_verdict_e verdict_d;

    // Choose the outcome for the packet finishing this cycle.
    always_comb begin
        verdict_d = VERDICT_NONE;
        if (rx_end) begin
            verdict_d = (rx_crc_ok && !rx_overrun) ? VERDICT_ACK : VERDICT_DROP;
        end
    end

    // Register the outcome as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) verdict_q <= VERDICT_NONE;
        else        verdict_q <= verdict_d;
    end

    a_r3_bad_crc_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && !rx_crc_ok) |=> (verdict_q == VERDICT_DROP));
    a_r4_overrun_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && rx_overrun) |=> (verdict_q == VERDICT_DROP));
    a_r2_idle_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_end |=> (verdict_q == VERDICT_NONE));
endmodule

// File: rtl/usb_err_counter.sv
// Per-descriptor error budget: loads from the descriptor, drops by one per
// erroring transaction, saturates at zero, and raises a sticky exhausted
// flag when a decrement reaches zero. A load wins over an error.
module usb_err_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             err_event,
    output logic [CNT_W-1:0] count_q,
    output logic             exhausted_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count and exhausted-flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q     <= '0;
            exhausted_q <= 1'b0;
        end else if (load) begin
            count_q     <= load_val;
            exhausted_q <= 1'b0;
        end else if (err_event && count_q != '0) begin
            count_q <= count_q - ONE;
            if (count_q == ONE) exhausted_q <= 1'b1;
        end
    end

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !load) |=> (count_q == '0));
    a_r11_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val) && !exhausted_q));
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted_q && !load) |=> exhausted_q);
    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (err_event && !load && count_q != '0) |=> (count_q == $past(count_q) - ONE));
    a_r12_hold_without_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_event && !load) |=> $stable(count_q));
endmodule

// File: rtl/usb_txn_err_tracker.sv
// Top of the host transaction error tracker. Joins the IN handshake
// decision, the turnaround timer and the error budget. A CRC failure and
// a timeout expiring in the same cycle count as a single error.
module usb_txn_err_tracker
    import usb_err_pkg::*;
#(
    parameter int CNT_W         = 2,
    parameter int TIMEOUT_BITS  = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eop_pulse,
    input  logic             bit_tick,
    input  logic             rx_start,
    input  logic             rx_end,
    input  logic             rx_crc_ok,
    input  logic             rx_overrun,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_load_val,
    output logic             send_ack,
    output logic             discard_data,
    output logic             turnaround_timeout,
    output logic [CNT_W-1:0] err_count,
    output logic             err_exhausted
);
    rx_verdict_e verdict;
    logic        expire_now;
    logic        err_event;

    usb_in_handshake u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_end     (rx_end),
        .rx_crc_ok  (rx_crc_ok),
        .rx_overrun (rx_overrun),
        .verdict_q  (verdict)
    );

    usb_turnaround_timer #(.LIMIT(TIMEOUT_BITS)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .eop_pulse  (eop_pulse),
        .bit_tick   (bit_tick),
        .rx_start   (rx_start),
        .expire_now (expire_now),
        .timeout_q  (turnaround_timeout)
    );

    // Errors that cost budget: bad CRC or timeout; an overrun alone does not.
    assign err_event = (rx_end && !rx_crc_ok) || expire_now;

    usb_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cnt_load),
        .load_val    (cnt_load_val),
        .err_event   (err_event),
        .count_q     (err_count),
        .exhausted_q (err_exhausted)
    );

    // Decode the registered verdict into the outward strobes.
    assign send_ack     = (verdict == VERDICT_ACK);
    assign discard_data = (verdict == VERDICT_DROP);

    a_r2_ack_xor_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_ack && discard_data));
    a_r4_overrun_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && rx_crc_ok && rx_overrun && !expire_now && !cnt_load) |=> $stable(err_count));
    a_r12_ack_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && rx_crc_ok && !rx_overrun && !expire_now && !cnt_load) |=> $stable(err_count));
endmodule

// File: tb/test_usb_txn_err_tracker.sv
module test_usb_txn_err_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eop_pulse = 0, bit_tick = 0, rx_start = 0, rx_end = 0;
    logic       rx_crc_ok = 0, rx_overrun = 0, cnt_load = 0;
    logic [1:0] cnt_load_val = 0;
    logic       send_ack, discard_data, turnaround_timeout, err_exhausted;
    logic [1:0] err_count;

    always #5 clk = ~clk;

    usb_txn_err_tracker i_usb_txn_err_tracker (
        .clk(clk), .rst_n(rst_n), .eop_pulse(eop_pulse), .bit_tick(bit_tick),
        .rx_start(rx_start), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
        .rx_overrun(rx_overrun), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .send_ack(send_ack), .discard_data(discard_data),
        .turnaround_timeout(turnaround_timeout), .err_count(err_count),
        .err_exhausted(err_exhausted)
    );

    typedef struct {
        logic       ack;
        logic       drop;
        logic       tmo;
        logic [1:0] cnt;
        logic       exh;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    // Requirement-level model state
    bit       m_armed = 0;
    int       m_bits  = 0;
    bit [1:0] m_cnt   = 0;
    bit       m_exh   = 0;

    task automatic compare(exp_t e);
        checks++;
        if (send_ack !== e.ack || discard_data !== e.drop || turnaround_timeout !== e.tmo ||
            err_count !== e.cnt || err_exhausted !== e.exh) begin
            errors++;
            $display("FAIL %s: got ack=%b drop=%b tmo=%b cnt=%0d exh=%b expected ack=%b drop=%b tmo=%b cnt=%0d exh=%b",
                     e.tag, send_ack, discard_data, turnaround_timeout, err_count, err_exhausted,
                     e.ack, e.drop, e.tmo, e.cnt, e.exh);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(bit eop, bit tick, bit rxs, bit rxe, bit crc, bit ovr,
                        bit ld, bit [1:0] ldv, string tag);
        exp_t e;
        bit   fire, err;
        @(negedge clk);
        eop_pulse = eop; bit_tick = tick; rx_start = rxs; rx_end = rxe;
        rx_crc_ok = crc; rx_overrun = ovr; cnt_load = ld; cnt_load_val = ldv;
        fire = m_armed && tick && !rxs && !eop && (m_bits == 18);
        err  = (rxe && !crc) || fire;
        e.ack  = rxe && crc && !ovr;
        e.drop = rxe && !(crc && !ovr);
        e.tmo  = fire;
        if (eop) begin m_armed = 1; m_bits = 0; end
        else if (rxs) begin m_armed = 0; m_bits = 0; end
        else if (m_armed && tick) begin
            if (m_bits == 18) begin m_armed = 0; m_bits = 0; end
            else m_bits++;
        end
        if (ld) begin m_cnt = ldv; m_exh = 0; end
        else if (err && m_cnt != 0) begin
            if (m_cnt == 1) m_exh = 1;
            m_cnt = m_cnt - 1;
        end
        e.cnt = m_cnt; e.exh = m_exh; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, 0, 2'd0, tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0, 0, 0, 2'd0, tag);
    endtask

    // Monitor: sample away from the edge and compare with the scoreboard.
    always @(posedge clk) begin
        #2;
        if (rst_n && exp_q.size() > 0) compare(exp_q.pop_front());
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        #2;
        r.ack = 0; r.drop = 0; r.tmo = 0; r.cnt = 0; r.exh = 0; r.tag = "R1 reset";
        compare(r);
        @(negedge clk); rst_n = 1;

        step(0, 0, 0, 0, 0, 0, 1, 2'd3, "R11 load 3");
        step(0, 0, 0, 1, 1, 0, 0, 2'd0, "R2 R12 good packet acked");
        idle("R2 single-cycle ack");
        step(0, 0, 0, 1, 0, 0, 0, 2'd0, "R3 R8 bad crc dropped, count 3->2");
        idle("R3 single-cycle drop");
        step(0, 0, 0, 1, 1, 1, 0, 2'd0, "R4 overrun dropped, count kept");
        step(0, 0, 0, 1, 0, 1, 0, 2'd0, "R4 R8 overrun with bad crc, count 2->1");
        step(0, 0, 0, 0, 0, 0, 1, 2'd2, "R11 reload 2");

        // R5: 19 ticks with gaps after eop
        step(1, 0, 0, 0, 0, 0, 0, 2'd0, "R5 eop");
        ticks(10, "R5 counting");
        idle("R5 gap does not advance");
        idle("R5 gap does not advance");
        ticks(9, "R5 expiry at 19th tick, count 2->1");
        ticks(25, "R5 no second timeout");

        // R6: response start stops timer
        step(1, 0, 0, 0, 0, 0, 0, 2'd0, "R6 eop");
        ticks(10, "R6 counting");
        step(0, 1, 1, 0, 0, 0, 0, 2'd0, "R6 rx start");
        ticks(20, "R6 stopped timer silent");
        step(1, 0, 0, 0, 0, 0, 0, 2'd0, "R6 eop");
        ticks(18, "R6 counting");
        step(0, 1, 1, 0, 0, 0, 0, 2'd0, "R6 rx start on 19th tick");
        ticks(3, "R6 no timeout after tie");

        // R7: restart mid-window; then exhaustion
        step(1, 0, 0, 0, 0, 0, 0, 2'd0, "R7 eop");
        ticks(10, "R7 counting");
        step(1, 1, 0, 0, 0, 0, 0, 2'd0, "R7 eop restart with tick");
        ticks(18, "R7 restarted window not yet expired");
        ticks(1, "R7 R10 timeout 1->0 exhausted");
        idle("R10 exhausted sticky");
        step(0, 0, 0, 1, 0, 0, 0, 2'd0, "R9 bad crc at zero no wrap");
        idle("R10 still exhausted");

        // R11: load beats error in same cycle
        step(0, 0, 0, 1, 0, 0, 1, 2'd2, "R11 load wins over bad crc");

        // R8: timeout and crc failure in same cycle -> one decrement
        step(1, 0, 0, 0, 0, 0, 0, 2'd0, "R8 eop");
        ticks(18, "R8 counting");
        step(0, 1, 0, 1, 0, 0, 0, 2'd0, "R8 timeout and bad crc together, 2->1");
        step(0, 0, 0, 1, 1, 0, 0, 2'd0, "R12 ack keeps count");
        idle("R12 idle");
        idle("drain");

        repeat (3) @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule